// File: doc/BRIEF.md
# Scatter-List Playback DMA Sequencer

This block generates the memory reads for one playback channel whose buffer is split into periods scattered through host memory. A table in host memory holds one 8-byte descriptor per period: the first 32-bit word is the period's start address and bits [31:16] of the second word give the period length in bytes. The sequencer fetches a descriptor and streams the period in 64-byte read bursts. Each returned word is forwarded to the sample FIFO's write port. At the end of the period it fetches the next descriptor, and after the last descriptor it returns to the first. Position is exposed as a descriptor index plus a byte offset within the period.

The table length is programmed as a byte offset of the last entry (entries minus one, times eight), so index bits are bits [5:3] of that field. Four position events (half period, period end, half buffer, buffer wrap), an end-of-audio event and two underrun reports are latched in a status word, each through its own mask bit. A stop flag with a 16-bit end offset halts the stream. Playback is started and stopped with a level `run` input.

The controller is one state machine. Its states are IDLE (waiting for `run`), DREQ (descriptor read request), DW0 and DW1 (descriptor words), BREQ (burst request), BDATA (burst beats) and HALT (stopped at the end offset). Its transitions are: IDLE→DREQ on `run` (position cleared), DREQ→DW0 on grant, DW0→DW1 and DW1→BREQ on each returned word, BREQ→BDATA on grant, BDATA→BREQ after a mid-period burst, BDATA→DREQ after a period-ending burst, BDATA→HALT when the end offset is crossed with stop enabled, and DREQ/BREQ/HALT→IDLE when `run` is low.

Top module: `pdl_play_seq`

## Requirements
- R1: After reset there is no memory request, the descriptor index, byte offset and status word are zero, and `irq` is low.
- R2: When `run` rises from idle, the index and offset are cleared and a descriptor read (`mem_kind`=0, two 32-bit beats) is issued at `list_base + 8*index`. Beat 0 is the period address and bits [31:16] of beat 1 are the period length.
- R3: Sample reads are bursts (`mem_kind`=1) of sixteen 32-bit beats at period address plus offset. Every beat drives `fifo_wr` with `fifo_wdata` equal to `mem_rdata`, and the offset advances by 64 after the last beat.
- R4: When the advanced offset reaches the period length, the offset returns to 0, the index steps to the next entry, and the index wraps to 0 after entry `list_last[5:3]`.
- R5: Status bit 0 is set by the burst that carries the offset across half the period length, and status bit 4 by the burst that ends the period.
- R6: Status bit 8 is set when the index steps to (entries/2), rounded down, and status bit 12 when the index wraps to 0.
- R7: A status bit is set only if its mask bit is 1. Set bits stay set until a 1 is written to the same bit of `stat_clr`, and `irq` is the OR of the status word.
- R8: With `stop_en` set, the burst that carries the offset across `end_off` sets status bit 24. No further request is made until `run` has gone low.
- R9: If `fifo_empty` is high in a cycle while a burst is outstanding, this is remembered. It is reported as status bit 30 at the next half-buffer step or as bit 31 at the next wrap, and is then forgotten.
- R10: No burst request is made while `fifo_room` is low.
- R11: Dropping `run` returns the block to idle at its next request point, and a later start begins again at entry 0, offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Channel start level |
| list_base | input | 32 | Address of the descriptor table |
| list_last | input | 6 | Byte offset of the last descriptor |
| end_off | input | 16 | Stop offset within a period |
| stop_en | input | 1 | Enables stopping at `end_off` |
| irq_mask | input | 32 | Per-bit status enable |
| stat_clr | input | 32 | Write-one-to-clear strobe for the status word |
| mem_req | output | 1 | Read request |
| mem_kind | output | 1 | 0 = descriptor (2 beats), 1 = burst (16 beats) |
| mem_addr | output | 32 | Read byte address |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |
| fifo_room | input | 1 | FIFO can take a whole burst |
| fifo_empty | input | 1 | FIFO has drained |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write data |
| cur_idx | output | 3 | Current descriptor index |
| cur_ptr | output | 16 | Byte offset within the current period |
| irq_stat | output | 32 | Latched status word |
| irq | output | 1 | Any status bit set |

## Verification
The assertions assume that every period length is a nonzero multiple of 64 and that the table holds 2 to 8 entries. They also assume that `list_last`, the descriptor contents and `stop_en` stay fixed while `run` is high, and that `mem_gnt` comes only while `mem_req` is high. The stimulus respects these limits: period lengths are drawn as random multiples of 64 from 64 to 512 bytes, table sizes are drawn from 2 to 8 entries, and configuration changes only while the channel is idle. Grant and beat timing are randomized with gaps within each transaction, while `run`, `fifo_room` and `fifo_empty` are changed only at fixed points of a transaction so that the expected position and status can be computed exactly.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_DREQ, S_DW0, S_DW1, S_BREQ, S_BDATA, S_HALT
    } pdl_state_t;

    // status bit positions (software decodes these)
    localparam int EV_HP = 0;
    localparam int EV_FP = 4;
    localparam int EV_HB = 8;
    localparam int EV_FB = 12;
    localparam int EV_EA = 24;
    localparam int EV_UH = 30;
    localparam int EV_UF = 31;
endpackage

// File: rtl/pdl_pos.sv
module pdl_pos #(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int PTR_W       = 16,
    parameter int IDX_W       = 3,
    parameter int BURST_BYTES = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               act,
    input  logic               clr,
    input  logic               adv,
    input  logic               ld_addr,
    input  logic               ld_size,
    input  logic [DW-1:0]      rdata,
    input  logic [IDX_W+2:0]   list_last,
    input  logic [PTR_W-1:0]   end_off,
    input  logic               stop_en,
    output logic [IDX_W-1:0]   cur_idx,
    output logic [PTR_W-1:0]   cur_ptr,
    output logic [AW-1:0]      paddr,
    output logic               ev_hp,
    output logic               ev_fp,
    output logic               ev_hb,
    output logic               ev_fb,
    output logic               hit_end
);
    localparam int LOFF_W = IDX_W + 3;

    logic [PTR_W-1:0] psize;
    logic [PTR_W:0]   ptr_nxt, half_sz;
    logic [IDX_W-1:0] last_idx, idx_nxt;
    logic [IDX_W:0]   nper, half_idx;

    assign last_idx = list_last[LOFF_W-1:3];
    assign nper     = {1'b0, last_idx} + (IDX_W+1)'(1);
    assign half_idx = nper >> 1;
    assign idx_nxt  = (cur_idx == last_idx) ? '0 : cur_idx + IDX_W'(1);
    assign ptr_nxt  = {1'b0, cur_ptr} + (PTR_W+1)'(BURST_BYTES);
    assign half_sz  = {1'b0, psize} >> 1;

    always_comb begin
        ev_hp   = adv && ({1'b0, cur_ptr} < half_sz) && (ptr_nxt >= half_sz);
        ev_fp   = adv && (ptr_nxt >= {1'b0, psize});
        ev_hb   = ev_fp && ({1'b0, idx_nxt} == half_idx);
        ev_fb   = ev_fp && (idx_nxt == '0);
        hit_end = adv && stop_en && (cur_ptr < end_off) &&
                  (ptr_nxt >= {1'b0, end_off});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_idx <= '0;
            cur_ptr <= '0;
            paddr   <= '0;
            psize   <= '0;
        end else begin
            if (clr) begin
                cur_idx <= '0;
                cur_ptr <= '0;
            end else if (adv) begin
                if (ev_fp) begin
                    cur_ptr <= '0;
                    cur_idx <= idx_nxt;
                end else begin
                    cur_ptr <= ptr_nxt[PTR_W-1:0];
                end
            end
            if (ld_addr) paddr <= AW'(rdata);
            if (ld_size) psize <= rdata[DW-1 -: PTR_W];
        end
    end

    // R3: bursts keep the offset on a burst boundary
    a_r3_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ptr % PTR_W'(BURST_BYTES)) == '0);

    // R4: index stays inside the programmed table while active
    a_r4_idx_in_list: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !clr) |-> (cur_idx <= last_idx));

    // R6: a wrap event is followed by index zero
    a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fb |=> (cur_idx == '0));
endmodule

// File: rtl/pdl_evt.sv
module pdl_evt (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ev_vec,
    input  logic        und_set,
    input  logic        hb,
    input  logic        fb,
    input  logic [31:0] mask,
    input  logic [31:0] clr,
    output logic [31:0] stat,
    output logic        irq
);
    import pdl_pkg::*;

    logic        und_q, und_now;
    logic [31:0] raw;

    assign und_now = und_q | und_set;

    always_comb begin
        raw        = ev_vec;
        raw[EV_UH] = hb && und_now;
        raw[EV_UF] = fb && und_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat  <= '0;
            und_q <= 1'b0;
        end else begin
            stat  <= (stat & ~clr) | (raw & mask);
            und_q <= (hb || fb) ? 1'b0 : und_now;
        end
    end

    assign irq = |stat;

    // R7: no bit appears in the status word unless its mask bit allowed it
    a_r7_masked_only: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(stat) & ~$past(mask)) == '0));

    // R9: an underrun pending at a wrap is reported in bit 31
    a_r9_und_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (fb && und_now && mask[EV_UF]) |=> stat[EV_UF]);
endmodule

// File: rtl/pdl_play_seq.sv
module pdl_play_seq #(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int PTR_W       = 16,
    parameter int IDX_W       = 3,
    parameter int BURST_BYTES = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [AW-1:0]      list_base,
    input  logic [IDX_W+2:0]   list_last,
    input  logic [PTR_W-1:0]   end_off,
    input  logic               stop_en,
    input  logic [31:0]        irq_mask,
    input  logic [31:0]        stat_clr,
    output logic               mem_req,
    output logic               mem_kind,
    output logic [AW-1:0]      mem_addr,
    input  logic               mem_gnt,
    input  logic               mem_rvalid,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               fifo_room,
    input  logic               fifo_empty,
    output logic               fifo_wr,
    output logic [DW-1:0]      fifo_wdata,
    output logic [IDX_W-1:0]   cur_idx,
    output logic [PTR_W-1:0]   cur_ptr,
    output logic [31:0]        irq_stat,
    output logic               irq
);
    import pdl_pkg::*;

    localparam int BEATS  = BURST_BYTES / (DW / 8);
    localparam int BEAT_W = $clog2(BEATS);

    pdl_state_t  state, nstate;
    logic [BEAT_W-1:0] beat_q;
    logic        beat_last, burst_done, start;
    logic        ld_addr, ld_size;
    logic [AW-1:0] paddr;
    logic        ev_hp, ev_fp, ev_hb, ev_fb, hit_end;
    logic [31:0] ev_vec;

    assign beat_last  = (beat_q == BEAT_W'(BEATS - 1));
    assign burst_done = (state == S_BDATA) && mem_rvalid && beat_last;
    assign start      = (state == S_IDLE) && run;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               beat_q <= '0;
        else if (state == S_BREQ && mem_gnt)      beat_q <= '0;
        else if (state == S_BDATA && mem_rvalid)  beat_q <= beat_q + BEAT_W'(1);
    end

    // next-state
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:  if (run) nstate = S_DREQ;
            S_DREQ:  if (!run) nstate = S_IDLE;
                     else if (mem_gnt) nstate = S_DW0;
            S_DW0:   if (mem_rvalid) nstate = S_DW1;
            S_DW1:   if (mem_rvalid) nstate = S_BREQ;
            S_BREQ:  if (!run) nstate = S_IDLE;
                     else if (fifo_room && mem_gnt) nstate = S_BDATA;
            S_BDATA: if (burst_done) begin
                         if (hit_end)    nstate = S_HALT;
                         else if (ev_fp) nstate = S_DREQ;
                         else            nstate = S_BREQ;
                     end
            S_HALT:  if (!run) nstate = S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_kind = 1'b0;
        mem_addr = '0;
        fifo_wr  = 1'b0;
        ld_addr  = 1'b0;
        ld_size  = 1'b0;
        unique case (state)
            S_DREQ: begin
                mem_req  = run;
                mem_addr = list_base + AW'({cur_idx, 3'b000});
            end
            S_DW0:   ld_addr = mem_rvalid;
            S_DW1:   ld_size = mem_rvalid;
            S_BREQ: begin
                mem_req  = run && fifo_room;
                mem_kind = 1'b1;
                mem_addr = paddr + AW'(cur_ptr);
            end
            S_BDATA: fifo_wr = mem_rvalid;
            S_IDLE, S_HALT: ;
            default: ;
        endcase
    end

    assign fifo_wdata = mem_rdata;

    always_comb begin
        ev_vec        = '0;
        ev_vec[EV_HP] = ev_hp;
        ev_vec[EV_FP] = ev_fp;
        ev_vec[EV_HB] = ev_hb;
        ev_vec[EV_FB] = ev_fb;
        ev_vec[EV_EA] = hit_end;
    end

    pdl_pos #(
        .AW(AW), .DW(DW), .PTR_W(PTR_W), .IDX_W(IDX_W), .BURST_BYTES(BURST_BYTES)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .act(state != S_IDLE), .clr(start),
        .adv(burst_done), .ld_addr(ld_addr), .ld_size(ld_size), .rdata(mem_rdata),
        .list_last(list_last), .end_off(end_off), .stop_en(stop_en),
        .cur_idx(cur_idx), .cur_ptr(cur_ptr), .paddr(paddr),
        .ev_hp(ev_hp), .ev_fp(ev_fp), .ev_hb(ev_hb), .ev_fb(ev_fb), .hit_end(hit_end)
    );

    pdl_evt u_evt (
        .clk(clk), .rst_n(rst_n), .ev_vec(ev_vec),
        .und_set((state == S_BDATA) && fifo_empty),
        .hb(ev_hb), .fb(ev_fb), .mask(irq_mask), .clr(stat_clr),
        .stat(irq_stat), .irq(irq)
    );

    // R8: once halted, nothing is requested in the following cycle
    a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HALT) |=> !mem_req);

    // R10: a burst grant only arrives while the FIFO had room
    a_r10_room_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BREQ && mem_gnt) |-> fifo_room);
endmodule

// File: tb/pdl_play_seq_bench.sv
module pdl_play_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [31:0] list_base = 32'h1000_0000;
    logic [5:0]  list_last = '0;
    logic [15:0] end_off = '0;
    logic        stop_en = 1'b0;
    logic [31:0] irq_mask = '0;
    logic [31:0] stat_clr = '0;
    logic        mem_req, mem_kind, fifo_wr, irq;
    logic [31:0] mem_addr, fifo_wdata, irq_stat;
    logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        fifo_room = 1'b1, fifo_empty = 1'b0;
    logic [2:0]  cur_idx;
    logic [15:0] cur_ptr;

    always #10 clk = ~clk;

    pdl_play_seq u_pdl_play_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .list_base(list_base),
        .list_last(list_last), .end_off(end_off), .stop_en(stop_en),
        .irq_mask(irq_mask), .stat_clr(stat_clr), .mem_req(mem_req),
        .mem_kind(mem_kind), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .fifo_room(fifo_room),
        .fifo_empty(fifo_empty), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .cur_idx(cur_idx), .cur_ptr(cur_ptr), .irq_stat(irq_stat), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model
    logic [31:0] d_addr [8];
    int          d_size [8];
    int          nper;
    int          m_idx, m_ptr, m_bursts;
    logic [31:0] m_paddr, m_stat;
    int          m_psize;
    bit          m_need_desc, m_und, m_halt, inject_empty;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] burst_events();
        logic [31:0] ev = '0;
        int nxt = m_ptr + 64;
        int half = m_psize / 2;
        int nidx;
        if (m_ptr < half && nxt >= half) ev[0] = 1'b1;
        if (stop_en && m_ptr < end_off && nxt >= end_off) begin
            ev[24] = 1'b1;
            m_halt = 1'b1;
        end
        if (nxt >= m_psize) begin
            ev[4] = 1'b1;
            nidx = (m_idx == nper - 1) ? 0 : m_idx + 1;
            if (nidx == nper / 2) begin
                ev[8] = 1'b1;
                if (m_und) begin ev[30] = 1'b1; m_und = 0; end
            end
            if (nidx == 0) begin
                ev[12] = 1'b1;
                if (m_und) begin ev[31] = 1'b1; m_und = 0; end
            end
            m_idx = nidx;
            m_ptr = 0;
            m_need_desc = 1'b1;
        end else begin
            m_ptr = nxt;
        end
        return ev;
    endfunction

    task automatic serve();
        int nb;
        logic [31:0] exp_addr;
        while (!mem_req) @(negedge clk);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        exp_addr = m_need_desc ? list_base + 32'(m_idx * 8) : m_paddr + 32'(m_ptr);
        check(m_need_desc ? "R2 desc kind" : "R3 burst kind", {31'b0, mem_kind},
              {31'b0, !m_need_desc});
        check(m_need_desc ? "R2 desc addr" : "R3 burst addr", mem_addr, exp_addr);
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        nb = m_need_desc ? 2 : 16;
        for (int k = 0; k < nb; k++) begin
            repeat ($urandom_range(0, 1)) @(negedge clk);
            mem_rvalid = 1'b1;
            if (m_need_desc)
                mem_rdata = (k == 0) ? d_addr[m_idx]
                                     : {16'(d_size[m_idx]), 16'($urandom)};
            else
                mem_rdata = $urandom;
            if (!m_need_desc && inject_empty && k == 0) begin
                fifo_empty = 1'b1;
                m_und = 1'b1;
            end
            if (k == 2) fifo_empty = 1'b0;
            #1;
            if (!m_need_desc) begin
                check("R3 fifo_wr", {31'b0, fifo_wr}, 32'd1);
                check("R3 fifo_wdata", fifo_wdata, mem_rdata);
            end
            @(negedge clk);
            mem_rvalid = 1'b0;
        end
        if (m_need_desc) begin
            m_paddr = d_addr[m_idx];
            m_psize = d_size[m_idx];
            m_need_desc = 1'b0;
        end else begin
            inject_empty = 1'b0;
            m_stat = m_stat | (burst_events() & irq_mask);
            m_bursts++;
            check("R4 index", {29'b0, cur_idx}, 32'(m_idx));
            check("R3 offset", {16'b0, cur_ptr}, 32'(m_ptr));
            check("R5/R6/R7 status", irq_stat, m_stat);
        end
    endtask

    task automatic setup(int n);
        nper = n;
        list_last = 6'((n - 1) * 8);
        for (int i = 0; i < 8; i++) d_addr[i] = 32'h2000_0000 + 32'(i) * 32'h0001_0000;
    endtask

    task automatic start_run();
        m_idx = 0; m_ptr = 0; m_bursts = 0;
        m_need_desc = 1'b1; m_und = 1'b0; m_halt = 1'b0;
        run = 1'b1;
        @(negedge clk);
    endtask

    task automatic stop_run();
        run = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_status();
        stat_clr = '1;
        @(negedge clk);
        stat_clr = '0;
        m_stat = '0;
        check("R7 cleared", irq_stat, 32'd0);
        check("R7 irq low", {31'b0, irq}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all R) act=timeout exp=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int tot;
        void'($urandom(32'd4711));
        m_stat = '0;
        inject_empty = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 mem_req", {31'b0, mem_req}, 32'd0);
        check("R1 index", {29'b0, cur_idx}, 32'd0);
        check("R1 offset", {16'b0, cur_ptr}, 32'd0);
        check("R1 status", irq_stat, 32'd0);
        check("R1 irq", {31'b0, irq}, 32'd0);

        // directed: four periods of mixed length, two whole buffers
        setup(4);
        d_size[0] = 128; d_size[1] = 192; d_size[2] = 64; d_size[3] = 256;
        irq_mask = '1;
        start_run();
        while (m_bursts < 20) serve();
        stop_run();
        check("R7 irq set", {31'b0, irq}, 32'd1);
        clear_status();

        // random tables and masks
        for (int t = 0; t < 4; t++) begin
            setup($urandom_range(2, 8));
            tot = 0;
            for (int i = 0; i < 8; i++) begin
                d_size[i] = 64 * $urandom_range(1, 8);
                if (i < nper) tot += d_size[i] / 64;
            end
            irq_mask = $urandom;
            start_run();
            while (m_bursts < tot + tot / 2) serve();
            stop_run();
            clear_status();
        end

        // R9 underrun reported at the half-buffer step
        setup(2);
        d_size[0] = 128; d_size[1] = 128;
        irq_mask = '1;
        start_run();
        serve();
        inject_empty = 1'b1;
        while (m_bursts < 4) serve();
        check("R9 half-buffer underrun", {31'b0, irq_stat[30]}, 32'd1);
        stop_run();
        clear_status();

        // R8 stop at end offset
        setup(3);
        for (int i = 0; i < 8; i++) d_size[i] = 256;
        stop_en = 1'b1; end_off = 16'd192;
        start_run();
        while (!m_halt) serve();
        for (int c = 0; c < 10; c++) begin
            check("R8 no request after stop", {31'b0, mem_req}, 32'd0);
            @(negedge clk);
        end
        check("R8 end-of-audio bit", {31'b0, irq_stat[24]}, 32'd1);
        stop_run();
        stop_en = 1'b0;
        clear_status();

        // R10 / R11 FIFO room and restart
        setup(2);
        d_size[0] = 256; d_size[1] = 256;
        fifo_room = 1'b0;
        start_run();
        serve();
        for (int c = 0; c < 10; c++) begin
            check("R10 no burst without room", {31'b0, mem_req}, 32'd0);
            @(negedge clk);
        end
        fifo_room = 1'b1;
        while (m_bursts < 3) serve();
        fifo_room = 1'b0;
        stop_run();
        check("R11 idle after run low", {31'b0, mem_req}, 32'd0);
        fifo_room = 1'b1;
        start_run();
        check("R11 restart index", {29'b0, cur_idx}, 32'd0);
        check("R11 restart offset", {16'b0, cur_ptr}, 32'd0);
        serve();
        serve();
        stop_run();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule